// File: doc/BRIEF.md
# Partitioned SRAM Address Decoder

This block turns a flat word address into the three select signals of a memory built from many independently enabled storage blocks: a one-hot block enable, a one-hot wordline and a one-hot word-in-row (column group) select. The address splits into a block field, a row field and a word field. The row field is split again into a high part, decoded on its own, and a small low part that gates the high decode. This second-level gating replaces a single flat row decoder, so the high-activity enable only drives a small gate load.

Each storage block owns its own row, word and write-data registers. Only the block named by the incoming address loads them, so the other blocks keep their inputs frozen and see no switching. A write commits one edge after the request is sampled. Read data from the active block passes through an output stage steered by the registered block enable and then into a read-data register. When there is no request, nothing at the select outputs moves, and the read data holds.

In the full configuration the address is 15 bits, with 32 blocks, 256 rows of four 32-bit words each, and a 6-to-64 high decode gated by a 2-bit low part. The default parameters keep 32 blocks and 4-word rows but build 32 rows per block, so the behavioural array stays small.

Top module: `sram_part_decoder`

## Requirements
- R1: Address fields, from the top down: block = addr[AW-1 -: BLK_BITS], row = the next ROWHI_BITS+ROWLO_BITS bits with the high part above the low part, and word = addr[COL_BITS-1:0]. With the defaults these are addr[11:7], addr[6:2] and addr[1:0].
- R2: Reset clears blk_en. After the rising edge that samples a read or write, blk_en has exactly one bit set, at the index of the block field.
- R3: After that edge, wl_sel has exactly one bit set, at index row = high*2^ROWLO_BITS + low. After reset it is zero.
- R4: After that edge, col_sel has exactly one bit set, at the index of the word field. After reset it is zero.
- R5: A write stores wdata at the address. A read sampled at edge k presents the stored word on rdata after edge k+1. Reset clears rdata.
- R6: A write changes no other address, including the same row and word offset in every other block.
- R7: In a cycle with neither rd_en nor wr_en, blk_en, wl_sel and col_sel keep their values, whatever addr and wdata do.
- R8: rdata changes only after an edge that follows a sampled read. Idle cycles and write-only cycles leave it unchanged.
- R9: When rd_en and wr_en are both set for one address, rdata shows the contents before the write, and the new word is stored.
- R10: A read requested in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request, sampled each edge |
| wr_en | input | 1 | Write request, sampled each edge |
| addr | input | AW | Word address (block, row, word fields) |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Registered read data |
| blk_en | output | NB | One-hot registered block enable |
| wl_sel | output | ROWS | One-hot wordline of the active block |
| col_sel | output | WPR | One-hot word-in-row select |

## Verification
A write commits its word on the same edge that samples the next request, and a read returns its word on the edge after. These two can therefore fall into one cycle in two ways. The first is a read and a write issued together to one address. The second is a read issued in the cycle right after a write to the same address. The bench provokes both and judges them against a model in the bench: the combined access must return the old word and leave the new one stored, and the following read must return the new word. A full write sweep and a pipelined full read sweep, with one access per cycle, also overlap each commit with the next capture in a different block or row.

// File: rtl/sram_pd_pkg.sv
package sram_pd_pkg;

   typedef struct packed {
      logic rd;
      logic wr;
   } sram_op_t;

   function automatic logic op_live(input sram_op_t op);
      return op.rd | op.wr;
   endfunction

endpackage

// File: rtl/sram_pd_onehot.sv
module sram_pd_onehot #(
   parameter int IN_W = 2,
   localparam int OUT_N = 1 << IN_W
) (
   input  logic             en,
   input  logic [IN_W-1:0]  sel,
   output logic [OUT_N-1:0] y
);

   for (genvar i = 0; i < OUT_N; i++) begin : g_out
      assign y[i] = en && (sel == IN_W'(i));
   end

endmodule

// File: rtl/sram_pd_rowdec.sv
module sram_pd_rowdec #(
   parameter int HI_BITS  = 3,
   parameter int LO_BITS  = 2,
   parameter bit ROW_GATED = 1'b1,
   localparam int ROW_BITS = HI_BITS + LO_BITS,
   localparam int ROWS     = 1 << ROW_BITS
) (
   input  logic                en,
   input  logic [ROW_BITS-1:0] row,
   output logic [ROWS-1:0]     wl
);

   localparam int HI_N = 1 << HI_BITS;
   localparam int LO_N = 1 << LO_BITS;

   if (ROW_GATED) begin : g_two_level
      logic [HI_N-1:0] hi_dec;
      logic [LO_N-1:0] lo_gate;

      // The high decode is static; only the small low decode carries the enable.
      sram_pd_onehot #(.IN_W(HI_BITS)) u_hi (
         .en  (1'b1),
         .sel (row[ROW_BITS-1:LO_BITS]),
         .y   (hi_dec)
      );
      sram_pd_onehot #(.IN_W(LO_BITS)) u_lo (
         .en  (en),
         .sel (row[LO_BITS-1:0]),
         .y   (lo_gate)
      );

      for (genvar h = 0; h < HI_N; h++) begin : g_hi
         for (genvar l = 0; l < LO_N; l++) begin : g_lo
            assign wl[h*LO_N + l] = hi_dec[h] & lo_gate[l];
         end
      end
   end else begin : g_flat
      sram_pd_onehot #(.IN_W(ROW_BITS)) u_flat (
         .en  (en),
         .sel (row),
         .y   (wl)
      );
   end

endmodule

// File: rtl/sram_pd_steer.sv
module sram_pd_steer #(
   parameter int NB     = 32,
   parameter int WORD_W = 32
) (
   input  logic [NB*WORD_W-1:0] words,
   input  logic [NB-1:0]        sel,
   output logic [WORD_W-1:0]    y
);

   always_comb begin
      y = '0;
      for (int b = 0; b < NB; b++) begin
         y = y | (words[b*WORD_W +: WORD_W] & {WORD_W{sel[b]}});
      end
   end

endmodule

// File: rtl/sram_pd_bank.sv
module sram_pd_bank #(
   parameter int HI_BITS   = 3,
   parameter int LO_BITS   = 2,
   parameter int COL_BITS  = 2,
   parameter int WORD_W    = 32,
   parameter bit ROW_GATED = 1'b1,
   localparam int ROW_BITS = HI_BITS + LO_BITS,
   localparam int ROWS     = 1 << ROW_BITS,
   localparam int WPR      = 1 << COL_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                act,
   input  logic                wr_go,
   input  logic [ROW_BITS-1:0] row_in,
   input  logic [COL_BITS-1:0] col_in,
   input  logic [WORD_W-1:0]   data_in,
   output logic [ROWS-1:0]     wl,
   output logic [WPR-1:0]      col,
   output logic [WORD_W-1:0]   rword
);

   localparam int IDX_W = ROW_BITS + COL_BITS;
   localparam int DEPTH = 1 << IDX_W;

   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q;
   logic [WORD_W-1:0]   data_q;
   logic [WORD_W-1:0]   cells [DEPTH];

   // Input registers move only for the block the request names.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         data_q <= '0;
      end else if (load) begin
         row_q  <= row_in;
         col_q  <= col_in;
         data_q <= data_in;
      end
   end

   always_ff @(posedge clk) begin
      if (act && wr_go) begin
         cells[{row_q, col_q}] <= data_q;
      end
   end

   assign rword = cells[{row_q, col_q}];

   sram_pd_rowdec #(
      .HI_BITS   (HI_BITS),
      .LO_BITS   (LO_BITS),
      .ROW_GATED (ROW_GATED)
   ) u_rowdec (
      .en  (act),
      .row (row_q),
      .wl  (wl)
   );

   sram_pd_onehot #(.IN_W(COL_BITS)) u_coldec (
      .en  (act),
      .sel (col_q),
      .y   (col)
   );

endmodule

// File: rtl/sram_part_decoder.sv
module sram_part_decoder
   import sram_pd_pkg::*;
#(
   parameter int BLK_BITS   = 5,
   parameter int ROWHI_BITS = 3,
   parameter int ROWLO_BITS = 2,
   parameter int COL_BITS   = 2,
   parameter int WORD_W     = 32,
   parameter bit ROW_GATED  = 1'b1,
   localparam int ROW_BITS = ROWHI_BITS + ROWLO_BITS,
   localparam int AW       = BLK_BITS + ROW_BITS + COL_BITS,
   localparam int NB       = 1 << BLK_BITS,
   localparam int ROWS     = 1 << ROW_BITS,
   localparam int WPR      = 1 << COL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic [NB-1:0]     blk_en,
   output logic [ROWS-1:0]   wl_sel,
   output logic [WPR-1:0]    col_sel
);

   if (BLK_BITS < 1 || BLK_BITS > 8) begin : g_bad_blk
      $error("sram_part_decoder: BLK_BITS out of range");
   end
   if (ROWHI_BITS < 1 || ROWLO_BITS < 1) begin : g_bad_row
      $error("sram_part_decoder: row fields must be at least one bit");
   end
   if (COL_BITS < 1 || WORD_W < 1) begin : g_bad_col
      $error("sram_part_decoder: word field and width must be positive");
   end

   sram_op_t            op;
   logic                live;
   logic [BLK_BITS-1:0] blk_field;
   logic [ROW_BITS-1:0] row_field;
   logic [COL_BITS-1:0] col_field;
   logic [NB-1:0]       blk_req;
   logic [NB-1:0]       blk_en_q;
   logic                rd_q;
   logic                wr_q;
   logic [WORD_W-1:0]   rdata_q;
   logic [WORD_W-1:0]   steered;

   logic [ROWS-1:0]      wl_all   [NB];
   logic [WPR-1:0]       col_all  [NB];
   logic [NB*WORD_W-1:0] word_flat;

   assign op        = '{rd: rd_en, wr: wr_en};
   assign live      = op_live(op);
   assign blk_field = addr[AW-1 -: BLK_BITS];
   assign row_field = addr[COL_BITS +: ROW_BITS];
   assign col_field = addr[COL_BITS-1:0];

   sram_pd_onehot #(.IN_W(BLK_BITS)) u_blkdec (
      .en  (live),
      .sel (blk_field),
      .y   (blk_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_en_q <= '0;
         rd_q     <= 1'b0;
         wr_q     <= 1'b0;
      end else begin
         rd_q <= op.rd;
         wr_q <= op.wr;
         if (live) begin
            blk_en_q <= blk_req;
         end
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [WORD_W-1:0] rword_b;

      sram_pd_bank #(
         .HI_BITS   (ROWHI_BITS),
         .LO_BITS   (ROWLO_BITS),
         .COL_BITS  (COL_BITS),
         .WORD_W    (WORD_W),
         .ROW_GATED (ROW_GATED)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (blk_req[b]),
         .act     (blk_en_q[b]),
         .wr_go   (wr_q),
         .row_in  (row_field),
         .col_in  (col_field),
         .data_in (wdata),
         .wl      (wl_all[b]),
         .col     (col_all[b]),
         .rword   (rword_b)
      );

      assign word_flat[b*WORD_W +: WORD_W] = rword_b;
   end

   always_comb begin
      wl_sel  = '0;
      col_sel = '0;
      for (int b = 0; b < NB; b++) begin
         wl_sel  = wl_sel  | wl_all[b];
         col_sel = col_sel | col_all[b];
      end
   end

   sram_pd_steer #(.NB(NB), .WORD_W(WORD_W)) u_steer (
      .words (word_flat),
      .sel   (blk_en_q),
      .y     (steered)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_q) begin
         rdata_q <= steered;
      end
   end

   assign rdata  = rdata_q;
   assign blk_en = blk_en_q;

endmodule

// File: rtl/sram_part_decoder_chk.sv
module sram_part_decoder_chk #(
   parameter int BLK_BITS   = 5,
   parameter int ROWHI_BITS = 3,
   parameter int ROWLO_BITS = 2,
   parameter int COL_BITS   = 2,
   parameter int WORD_W     = 32,
   localparam int ROW_BITS = ROWHI_BITS + ROWLO_BITS,
   localparam int AW       = BLK_BITS + ROW_BITS + COL_BITS,
   localparam int NB       = 1 << BLK_BITS,
   localparam int ROWS     = 1 << ROW_BITS,
   localparam int WPR      = 1 << COL_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic [AW-1:0]     addr,
   input logic [WORD_W-1:0] rdata,
   input logic [NB-1:0]     blk_en,
   input logic [ROWS-1:0]   wl_sel,
   input logic [WPR-1:0]    col_sel
);

   logic rd_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_d <= 1'b0;
      else        rd_d <= rd_en;
   end

   assert_blk_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || wr_en) |=> $onehot(blk_en));

   assert_blk_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || wr_en) |=> blk_en[$past(addr[AW-1 -: BLK_BITS])]);

   assert_wl_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_en != '0) |-> $onehot(wl_sel));

   assert_col_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_en != '0) |-> $onehot(col_sel));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en || wr_en) |=> ($stable(blk_en) && $stable(wl_sel) && $stable(col_sel)));

   assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_d |=> $stable(rdata));

endmodule

bind sram_part_decoder sram_part_decoder_chk #(
   .BLK_BITS   (BLK_BITS),
   .ROWHI_BITS (ROWHI_BITS),
   .ROWLO_BITS (ROWLO_BITS),
   .COL_BITS   (COL_BITS),
   .WORD_W     (WORD_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en   (rd_en),
   .wr_en   (wr_en),
   .addr    (addr),
   .rdata   (rdata),
   .blk_en  (blk_en),
   .wl_sel  (wl_sel),
   .col_sel (col_sel)
);

// File: tb/sram_part_decoder_test.sv
module sram_part_decoder_test;

   localparam int BB   = 5;
   localparam int RB   = 5;
   localparam int CB   = 2;
   localparam int AW   = BB + RB + CB;
   localparam int NA   = 1 << AW;
   localparam int NB   = 1 << BB;
   localparam int ROWS = 1 << RB;
   localparam int WPR  = 1 << CB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NB-1:0] blk_en;
   logic [ROWS-1:0] wl_sel;
   logic [WPR-1:0]  col_sel;

   int  errors = 0;
   int  checks = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   sram_part_decoder uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .blk_en  (blk_en),
      .wl_sel  (wl_sel),
      .col_sel (col_sel)
   );

   function automatic logic [31:0] pat(input int a, input logic [31:0] salt);
      return (32'(a) * 32'h9E37_79B1) ^ salt;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic w, input int a, input logic [31:0] d);
      rd_en = r;
      wr_en = w;
      addr  = AW'(a);
      wdata = d;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_sel(input int a);
      logic [NB-1:0]   eb = NB'(1) << (a >> (RB + CB));
      logic [ROWS-1:0] ew = ROWS'(1) << ((a >> CB) % ROWS);
      logic [WPR-1:0]  ec = WPR'(1) << (a % WPR);
      check(blk_en == eb, "R2 block enable", 64'(blk_en), 64'(eb));
      check(wl_sel == ew, "R3 wordline", 64'(wl_sel), 64'(ew));
      check(col_sel == ec, "R4 word select", 64'(col_sel), 64'(ec));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [NB-1:0]   hb;
      logic [ROWS-1:0] hw;
      logic [WPR-1:0]  hc;
      logic [31:0]     hr;
      int a_x;
      int b_x;

      repeat (3) @(negedge clk);
      check(blk_en == '0, "R2 reset", 64'(blk_en), 64'd0);
      check(wl_sel == '0, "R3 reset", 64'(wl_sel), 64'd0);
      check(col_sel == '0, "R4 reset", 64'(col_sel), 64'd0);
      check(rdata == '0, "R5 reset", 64'(rdata), 64'd0);
      rst_n = 1'b1;
      tick();

      // R1 R2 R3 R4: every address written back to back, selects checked each cycle.
      for (int a = 0; a < NA; a++) begin
         drive(1'b0, 1'b1, a, pat(a, 32'h5A5A_0000));
         tick();
         check_sel(a);
      end

      // R5 R6: pipelined read sweep; each word must be its own distinct pattern.
      for (int i = 0; i <= NA; i++) begin
         if (i < NA) drive(1'b1, 1'b0, i, 32'h0);
         else        drive(1'b0, 1'b0, 0, 32'h0);
         tick();
         if (i < NA) check_sel(i);
         if (i > 0) check(rdata == pat(i - 1, 32'h5A5A_0000), "R5 read back", 64'(rdata),
                          64'(pat(i - 1, 32'h5A5A_0000)));
      end

      // R7 R8: idle cycles with moving addr and wdata.
      hb = blk_en; hw = wl_sel; hc = col_sel; hr = rdata;
      for (int k = 0; k < 4; k++) begin
         drive(1'b0, 1'b0, (k * 1237 + 99) % NA, 32'hDEAD_0000 + 32'(k));
         tick();
         check(blk_en == hb, "R7 idle blk_en", 64'(blk_en), 64'(hb));
         check(wl_sel == hw, "R7 idle wl_sel", 64'(wl_sel), 64'(hw));
         check(col_sel == hc, "R7 idle col_sel", 64'(col_sel), 64'(hc));
         check(rdata == hr, "R8 idle rdata", 64'(rdata), 64'(hr));
      end

      // R8: write-only access leaves rdata alone.
      drive(1'b0, 1'b1, 77, pat(77, 32'h0F0F_0F0F));
      tick();
      drive(1'b0, 1'b0, 0, 32'h0);
      tick();
      check(rdata == hr, "R8 write-only rdata", 64'(rdata), 64'(hr));

      // R9: read and write together return the old word, store the new one.
      a_x = (9 << (RB + CB)) | (13 << CB) | 2;
      drive(1'b1, 1'b1, a_x, 32'hCAFE_F00D);
      tick();
      drive(1'b0, 1'b0, 0, 32'h0);
      tick();
      check(rdata == pat(a_x, 32'h5A5A_0000), "R9 old word", 64'(rdata),
            64'(pat(a_x, 32'h5A5A_0000)));
      drive(1'b1, 1'b0, a_x, 32'h0);
      tick();
      drive(1'b0, 1'b0, 0, 32'h0);
      tick();
      check(rdata == 32'hCAFE_F00D, "R9 new word stored", 64'(rdata), 64'h0CAFE_F00D);

      // R10: read in the cycle right after a write to the same address.
      b_x = (30 << (RB + CB)) | (5 << CB) | 1;
      drive(1'b0, 1'b1, b_x, 32'h1234_5678);
      tick();
      drive(1'b1, 1'b0, b_x, 32'h0);
      tick();
      drive(1'b0, 1'b0, 0, 32'h0);
      tick();
      check(rdata == 32'h1234_5678, "R10 write then read", 64'(rdata), 64'h1234_5678);

      // R6: same row and word offset in every other block keeps its pattern.
      for (int b = 0; b < NB; b++) begin
         int o = (b << (RB + CB)) | (a_x % (1 << (RB + CB)));
         if (b != 9) begin
            drive(1'b1, 1'b0, o, 32'h0);
            tick();
            drive(1'b0, 1'b0, 0, 32'h0);
            tick();
            check(rdata == pat(o, 32'h5A5A_0000), "R6 other block untouched", 64'(rdata),
                  64'(pat(o, 32'h5A5A_0000)));
         end
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule